// File: doc/BRIEF.md
# Write-Invalidate Snooping Cache Coherence Controller

This block keeps one cache consistent with its peers on a shared bus. Every line sits in one of three states: invalid, shared (clean, possibly copied elsewhere) or exclusive (sole owner, possibly dirty). A small direct-mapped tag and state array holds the lines. Processor reads and writes are looked up in this array. A hit is completed locally. A miss, or an upgrade of a shared line before a write, produces a bus request. A request that evicts an exclusive line first writes that line back.

The controller also watches the misses that other caches put on the bus. A matching exclusive line is handed over to the bus: on a foreign read it drops to shared, and on a foreign write it becomes invalid. A matching shared line is only invalidated, and only by a foreign write. Each bus request is treated as atomic. The request stays on the bus until the bus side acknowledges it, and the line's new tag and state are written in the cycle of that acknowledge. Snoops win over processor requests in the same cycle, and the processor side waits on a ready signal.

A line address is split into an index (the low `IDX_W` bits) and a tag (the remaining upper bits).

Top module: `snoop_coherence_ctrl`

## Requirements
- R1: Reset puts every line in the invalid state. After reset the outputs are idle (no bus request, no done), and the first processor access to any address misses.
- R2: A processor read that hits a shared or exclusive line raises `cpu_done` and `cpu_hit` one cycle after acceptance, with no bus request.
- R3: A processor read that misses, with a victim that is not exclusive, puts bus command 2'b01 (read miss) on the bus with the requested line address. After the acknowledge, `cpu_done` rises with `cpu_hit` low and the line becomes shared.
- R4: A processor write that misses, with a victim that is not exclusive, puts bus command 2'b10 (write miss) on the bus with the requested address. After the acknowledge the line becomes exclusive.
- R5: A processor write that hits an exclusive line completes like R2 and issues no bus request.
- R6: A processor write that hits a shared line issues command 2'b10 for that address. After the acknowledge the line becomes exclusive and the write reports `cpu_hit` low.
- R7: A miss whose victim line is exclusive first issues command 2'b11 (writeback) with the victim's address. Only after that acknowledge does it issue the R3 or R4 miss command.
- R8: A snooped read miss (`snoop_cmd` 2'b01) that matches a shared line causes no flush and leaves the line shared.
- R9: A snooped read miss that matches an exclusive line raises `snoop_flush` for one cycle, in the cycle after the snoop, with that address, and downgrades the line to shared.
- R10: A snooped write miss (`snoop_cmd` 2'b10) that matches a shared line invalidates it without a flush.
- R11: A snooped write miss that matches an exclusive line flushes it as in R9 and invalidates it.
- R12: A snoop with command 2'b00 or 2'b11, or one whose tag does not match a valid line, changes no line and causes no flush.
- R13: While `snoop_valid` is high, `cpu_ready` is low and no processor request is accepted.
- R14: A bus request keeps its valid, command and address unchanged until acknowledged. The command is never 2'b00 while valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Processor line address |
| cpu_ready | output | 1 | Request is accepted this cycle when valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completed request was served without the bus |
| bus_req_valid | output | 1 | Bus request outstanding |
| bus_req_cmd | output | 2 | 01 read miss, 10 write miss, 11 writeback |
| bus_req_addr | output | ADDR_W | Line address of the bus request |
| bus_ack | input | 1 | Bus side completes the outstanding request |
| snoop_valid | input | 1 | Another cache's request is on the bus |
| snoop_cmd | input | 2 | Command of the snooped request |
| snoop_addr | input | ADDR_W | Line address of the snooped request |
| snoop_flush | output | 1 | This cache supplies the snooped block |
| snoop_flush_addr | output | ADDR_W | Address of the supplied block |

## Verification
The bench builds the controller with an 8-bit line address and three index bits: eight lines with five tag bits. Random addresses are drawn from only four tags, so conflict misses on exclusive victims, upgrades of shared lines and snoops that match live lines occur often. A random hold before each acknowledge exercises the request-hold rule. A directed cycle that raises a snoop and a processor request together exercises the snoop-priority rule.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'b00,
    LS_S = 2'b01,
    LS_E = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'b00,
    CMD_RD_MISS = 2'b01,
    CMD_WR_MISS = 2'b10,
    CMD_WBACK   = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] cpu_ridx_i,
  output logic [TAG_W-1:0] cpu_tag_o,
  output line_st_e         cpu_st_o,
  input  logic [IDX_W-1:0] snp_ridx_i,
  output logic [TAG_W-1:0] snp_tag_o,
  output line_st_e         snp_st_o,
  input  logic             cpu_we_i,
  input  logic [IDX_W-1:0] cpu_widx_i,
  input  logic [TAG_W-1:0] cpu_wtag_i,
  input  line_st_e         cpu_wst_i,
  input  logic             snp_we_i,
  input  logic [IDX_W-1:0] snp_widx_i,
  input  line_st_e         snp_wst_i
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  line_st_e         st_q    [LINES];

  // tags: no reset, single write port, so the array maps onto memory
  always_ff @(posedge clk) begin
    if (cpu_we_i) tag_mem[cpu_widx_i] <= cpu_wtag_i;
  end

  // states: reset to invalid; the processor-side commit wins a same-line clash
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_I;
    end else begin
      if (snp_we_i) st_q[snp_widx_i] <= snp_wst_i;
      if (cpu_we_i) st_q[cpu_widx_i] <= cpu_wst_i;
    end
  end

  assign cpu_tag_o = tag_mem[cpu_ridx_i];
  assign cpu_st_o  = st_q[cpu_ridx_i];
  assign snp_tag_o = tag_mem[snp_ridx_i];
  assign snp_st_o  = st_q[snp_ridx_i];

  assert_reset_invalid_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpu_st_o == LS_I && snp_st_o == LS_I));
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snoop_valid_i,
  input  logic [1:0]        snoop_cmd_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic [IDX_W-1:0]  idx_o,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_st_e          line_st_i,
  output logic              we_o,
  output line_st_e          wst_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] flush_addr_o
);
  logic is_rd, is_wr, match, give_data;

  assign idx_o = snoop_addr_i[IDX_W-1:0];
  assign is_rd = snoop_cmd_i == CMD_RD_MISS;
  assign is_wr = snoop_cmd_i == CMD_WR_MISS;
  assign match = snoop_valid_i && (line_st_i != LS_I)
               && (line_tag_i == snoop_addr_i[ADDR_W-1:IDX_W]);

  assign give_data = match && (line_st_i == LS_E) && (is_rd || is_wr);
  assign we_o      = match && (is_wr || (is_rd && line_st_i == LS_E));
  assign wst_o     = is_wr ? LS_I : LS_S;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_o      <= 1'b0;
      flush_addr_o <= '0;
    end else begin
      flush_o <= give_data;
      if (give_data) flush_addr_o <= snoop_addr_i;
    end
  end

  assert_flush_owner_R9: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> ($past(snoop_valid_i) && $past(line_st_i) == LS_E));

  assert_ignore_other_R12: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid_i && (snoop_cmd_i == CMD_WBACK || snoop_cmd_i == CMD_NONE)) |=> !flush_o);
endmodule

// File: rtl/coh_cpu_fsm.sv
module coh_cpu_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid_i,
  input  logic              cpu_req_write_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  input  logic              snoop_busy_i,
  output logic              cpu_ready_o,
  output logic              cpu_done_o,
  output logic              cpu_hit_o,
  output logic [IDX_W-1:0]  lookup_idx_o,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_st_e          line_st_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  widx_o,
  output logic [TAG_W-1:0]  wtag_o,
  output line_st_e          wst_o,
  output logic              bus_req_valid_o,
  output logic [1:0]        bus_req_cmd_o,
  output logic [ADDR_W-1:0] bus_req_addr_o,
  input  logic              bus_ack_i
);
  typedef enum logic [1:0] {FS_IDLE, FS_WBACK, FS_FETCH} fsm_e;

  fsm_e              st_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_write_q;
  bus_cmd_e          cmd_q;
  logic              accept, hit;
  bus_cmd_e          miss_cmd;

  assign lookup_idx_o = cpu_req_addr_i[IDX_W-1:0];
  assign cpu_ready_o  = (st_q == FS_IDLE) && !snoop_busy_i;
  assign accept       = cpu_ready_o && cpu_req_valid_i;
  assign hit          = (line_st_i != LS_I) && (line_tag_i == cpu_req_addr_i[ADDR_W-1:IDX_W]);
  assign miss_cmd     = cpu_req_write_i ? CMD_WR_MISS : CMD_RD_MISS;
  assign bus_req_cmd_o = cmd_q;

  // commit on acknowledge: the victim goes invalid, the fetched line takes its new state
  assign we_o   = bus_ack_i && (st_q != FS_IDLE);
  assign widx_o = req_addr_q[IDX_W-1:0];
  assign wtag_o = (st_q == FS_FETCH) ? req_addr_q[ADDR_W-1:IDX_W] : bus_req_addr_o[ADDR_W-1:IDX_W];
  assign wst_o  = (st_q == FS_FETCH) ? (req_write_q ? LS_E : LS_S) : LS_I;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q            <= FS_IDLE;
      req_addr_q      <= '0;
      req_write_q     <= 1'b0;
      cmd_q           <= CMD_NONE;
      bus_req_valid_o <= 1'b0;
      bus_req_addr_o  <= '0;
      cpu_done_o      <= 1'b0;
      cpu_hit_o       <= 1'b0;
    end else begin
      cpu_done_o <= 1'b0;
      cpu_hit_o  <= 1'b0;
      unique case (st_q)
        FS_IDLE: if (accept) begin
          req_addr_q  <= cpu_req_addr_i;
          req_write_q <= cpu_req_write_i;
          if (hit && (!cpu_req_write_i || line_st_i == LS_E)) begin
            cpu_done_o <= 1'b1;
            cpu_hit_o  <= 1'b1;
          end else if (hit) begin
            bus_req_valid_o <= 1'b1;
            cmd_q           <= CMD_WR_MISS;
            bus_req_addr_o  <= cpu_req_addr_i;
            st_q            <= FS_FETCH;
          end else if (line_st_i == LS_E) begin
            bus_req_valid_o <= 1'b1;
            cmd_q           <= CMD_WBACK;
            bus_req_addr_o  <= {line_tag_i, cpu_req_addr_i[IDX_W-1:0]};
            st_q            <= FS_WBACK;
          end else begin
            bus_req_valid_o <= 1'b1;
            cmd_q           <= miss_cmd;
            bus_req_addr_o  <= cpu_req_addr_i;
            st_q            <= FS_FETCH;
          end
        end
        FS_WBACK: if (bus_ack_i) begin
          cmd_q          <= req_write_q ? CMD_WR_MISS : CMD_RD_MISS;
          bus_req_addr_o <= req_addr_q;
          st_q           <= FS_FETCH;
        end
        FS_FETCH: if (bus_ack_i) begin
          bus_req_valid_o <= 1'b0;
          cmd_q           <= CMD_NONE;
          cpu_done_o      <= 1'b1;
          st_q            <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assert_bus_hold_R14: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid_o && !bus_ack_i) |=>
      (bus_req_valid_o && $stable(bus_req_cmd_o) && $stable(bus_req_addr_o)));

  assert_bus_cmd_R14: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid_o |-> (bus_req_cmd_o != CMD_NONE));

  assert_snoop_first_R13: assert property (@(posedge clk) disable iff (rst)
    (snoop_busy_i && st_q == FS_IDLE) |=> (!bus_req_valid_o && !cpu_done_o));

  assert_wb_victim_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req_valid_o) && bus_req_cmd_o == CMD_WBACK) |-> ($past(line_st_i) == LS_E));

  assert_hit_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_done_o && cpu_hit_o) |-> !bus_req_valid_o);
endmodule

// File: rtl/snoop_coherence_ctrl.sv
module snoop_coherence_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_ack,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_flush,
  output logic [ADDR_W-1:0] snoop_flush_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] c_ridx, s_ridx, c_widx, s_widx;
  logic [TAG_W-1:0] c_tag, s_tag, c_wtag;
  line_st_e         c_st, s_st, c_wst, s_wst;
  logic             c_we, s_we;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .cpu_ridx_i(c_ridx), .cpu_tag_o(c_tag), .cpu_st_o(c_st),
    .snp_ridx_i(s_ridx), .snp_tag_o(s_tag), .snp_st_o(s_st),
    .cpu_we_i(c_we), .cpu_widx_i(c_widx), .cpu_wtag_i(c_wtag), .cpu_wst_i(c_wst),
    .snp_we_i(s_we), .snp_widx_i(s_widx), .snp_wst_i(s_wst)
  );

  assign s_widx = s_ridx;

  coh_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snoop_valid_i(snoop_valid), .snoop_cmd_i(snoop_cmd), .snoop_addr_i(snoop_addr),
    .idx_o(s_ridx), .line_tag_i(s_tag), .line_st_i(s_st),
    .we_o(s_we), .wst_o(s_wst),
    .flush_o(snoop_flush), .flush_addr_o(snoop_flush_addr)
  );

  coh_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cpu (
    .clk(clk), .rst(rst),
    .cpu_req_valid_i(cpu_req_valid), .cpu_req_write_i(cpu_req_write),
    .cpu_req_addr_i(cpu_req_addr), .snoop_busy_i(snoop_valid),
    .cpu_ready_o(cpu_ready), .cpu_done_o(cpu_done), .cpu_hit_o(cpu_hit),
    .lookup_idx_o(c_ridx), .line_tag_i(c_tag), .line_st_i(c_st),
    .we_o(c_we), .widx_o(c_widx), .wtag_o(c_wtag), .wst_o(c_wst),
    .bus_req_valid_o(bus_req_valid), .bus_req_cmd_o(bus_req_cmd),
    .bus_req_addr_o(bus_req_addr), .bus_ack_i(bus_ack)
  );
endmodule

// File: tb/test_snoop_coherence_ctrl.sv
`timescale 1ns/1ps
module test_snoop_coherence_ctrl;
  localparam int AW = 8;
  localparam int IW = 3;
  localparam int NL = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic cpu_ready, cpu_done, cpu_hit, bus_req_valid, snoop_flush;
  logic [1:0] bus_req_cmd;
  logic [AW-1:0] bus_req_addr, snoop_flush_addr;
  logic bus_ack = 1'b0, snoop_valid = 1'b0;
  logic [1:0] snoop_cmd = 2'b00;
  logic [AW-1:0] snoop_addr = '0;

  int total = 0, bad = 0, cycles = 0;
  logic [AW-IW-1:0] mtag [NL];
  logic [1:0]       mst  [NL];   // 0 invalid, 1 shared, 2 exclusive

  always #2 clk = ~clk;

  snoop_coherence_ctrl #(.ADDR_W(AW), .IDX_W(IW)) i_snoop_coherence_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_ack(bus_ack),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .snoop_flush(snoop_flush), .snoop_flush_addr(snoop_flush_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [AW-1:0] a);
    return mst[a[IW-1:0]] != 2'd0 && mtag[a[IW-1:0]] == a[AW-1:IW];
  endfunction

  task automatic cpu_op(input bit wr, input logic [AW-1:0] a);
    int idx = int'(a[IW-1:0]);
    bit h = model_hit(a);
    int n;
    logic [1:0] c [2];
    logic [AW-1:0] ad [2];
    string rq;
    if (h && (!wr || mst[idx] == 2'd2)) begin n = 0; rq = wr ? "R5" : "R2"; end
    else if (h) begin n = 1; c[0] = 2'b10; ad[0] = a; rq = "R6"; end
    else if (mst[idx] == 2'd2) begin
      n = 2; c[0] = 2'b11; ad[0] = {mtag[idx], a[IW-1:0]};
      c[1] = wr ? 2'b10 : 2'b01; ad[1] = a; rq = "R7";
    end else begin n = 1; c[0] = wr ? 2'b10 : 2'b01; ad[0] = a; rq = wr ? "R4" : "R3"; end
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (n == 0) begin
      chk(cpu_done && cpu_hit, rq, {cpu_done, cpu_hit}, 3);
      chk(!bus_req_valid, rq, bus_req_valid, 0);
    end else begin
      for (int k = 0; k < n; k++) begin
        chk(bus_req_valid && bus_req_cmd == c[k], rq, {bus_req_valid, bus_req_cmd}, {1'b1, c[k]});
        chk(bus_req_addr == ad[k], rq, bus_req_addr, ad[k]);
        for (int w = 0; w < int'($urandom % 3); w++) begin
          @(negedge clk);
          chk(bus_req_valid && bus_req_cmd == c[k] && bus_req_addr == ad[k], "R14",
              {bus_req_valid, bus_req_cmd, bus_req_addr}, {1'b1, c[k], ad[k]});
        end
        bus_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_ack = 1'b0;
      end
      chk(cpu_done && !cpu_hit && !bus_req_valid, rq, {cpu_done, cpu_hit, bus_req_valid}, 4);
      mtag[idx] = a[AW-1:IW];
      mst[idx]  = wr ? 2'd2 : 2'd1;
    end
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a);
    int idx = int'(a[IW-1:0]);
    bit h = model_hit(a);
    bit exp_fl = h && mst[idx] == 2'd2 && (cmd == 2'b01 || cmd == 2'b10);
    string rq;
    if (!h || cmd == 2'b00 || cmd == 2'b11) rq = "R12";
    else if (cmd == 2'b01) rq = (mst[idx] == 2'd2) ? "R9" : "R8";
    else rq = (mst[idx] == 2'd2) ? "R11" : "R10";
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = cmd; snoop_addr = a;
    #1;
    chk(!cpu_ready, "R13", cpu_ready, 0);
    @(posedge clk);
    @(negedge clk);
    snoop_valid = 1'b0;
    chk(snoop_flush == exp_fl, rq, snoop_flush, exp_fl);
    if (exp_fl) chk(snoop_flush_addr == a, rq, snoop_flush_addr, a);
    if (h && cmd == 2'b10) mst[idx] = 2'd0;
    else if (h && cmd == 2'b01 && mst[idx] == 2'd2) mst[idx] = 2'd1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < NL; i++) begin mst[i] = 2'd0; mtag[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req_valid && !cpu_done && cpu_ready && !snoop_flush, "R1",
        {bus_req_valid, cpu_done, cpu_ready, snoop_flush}, 2);
    // R1: first read after reset must miss
    cpu_op(1'b0, 8'h05);
    cpu_op(1'b0, 8'h05);          // R2 hit on shared
    cpu_op(1'b1, 8'h05);          // R6 upgrade
    cpu_op(1'b1, 8'h05);          // R5 local write
    cpu_op(1'b0, 8'h25);          // R7 exclusive victim written back first
    snoop(2'b01, 8'h25);          // R8
    cpu_op(1'b0, 8'h25);          // still shared: hit
    cpu_op(1'b1, 8'h0A);          // R4
    snoop(2'b01, 8'h0A);          // R9 flush, downgrade
    cpu_op(1'b1, 8'h0A);          // upgrade proves shared
    snoop(2'b10, 8'h0A);          // R11 flush, invalidate
    cpu_op(1'b0, 8'h0A);          // misses after invalidation
    snoop(2'b10, 8'h0A);          // R10
    cpu_op(1'b1, 8'h0A);          // write miss again
    snoop(2'b11, 8'h0A);          // R12 writeback command ignored
    snoop(2'b00, 8'h0A);          // R12 none ignored
    snoop(2'b10, 8'h1A);          // R12 tag mismatch ignored
    cpu_op(1'b1, 8'h0A);          // still exclusive: local hit
    // R13: snoop and processor request in the same cycle
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h33;
    snoop_valid = 1'b1; snoop_cmd = 2'b01; snoop_addr = 8'h77;
    #1;
    chk(!cpu_ready, "R13", cpu_ready, 0);
    @(posedge clk);
    @(negedge clk);
    snoop_valid = 1'b0; cpu_req_valid = 1'b0;
    chk(!bus_req_valid && !cpu_done, "R13", {bus_req_valid, cpu_done}, 0);
    // random mix
    for (int r = 0; r < 400; r++) begin
      logic [AW-1:0] a = {5'($urandom % 4), 3'($urandom % NL)};
      int sel = int'($urandom % 6);
      if (sel < 2) cpu_op(1'b0, a);
      else if (sel < 4) cpu_op(1'b1, a);
      else snoop(2'($urandom % 4), a);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule